// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is an iterative integer multiply and divide engine that sits beside a processor's main integer pipeline. A multiply or divide is launched with a single start pulse, an operation code and two operands. The engine then works on its own for a fixed number of cycles while the pipeline carries on. The results land in two dedicated result registers, called HI and LO. A multiply puts the upper half of its double-width product in HI and the lower half in LO. A divide puts the quotient in LO and the remainder in HI.

The pipeline reads HI or LO through a read port. While an operation is still in flight, a read request is answered with a stall, so software never sees a half-finished result. A separate write port loads either register directly. This lets an exception handler put back the values it saved earlier. Signed operands are converted to magnitudes before the iterations and the signs are fixed afterwards, so the same shift-add and restoring-subtract datapath serves all four operation codes.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO both read zero, and busy_o and stall_o are low.
- R2: Operation code 2'b00 multiplies the operands as two's complement numbers. HI receives bits [2W-1:W] of the signed product and LO receives bits [W-1:0].
- R3: Operation code 2'b01 multiplies the operands as unsigned numbers, with the same split of the product between HI and LO.
- R4: Operation code 2'b10 divides as signed numbers with a nonzero divisor. LO receives the quotient truncated toward zero, and HI receives the remainder, which carries the sign of the dividend. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of zero.
- R5: Operation code 2'b11 divides as unsigned numbers with a nonzero divisor. LO receives the quotient and HI the remainder.
- R6: A divide by zero, signed or unsigned, raises no error. LO becomes all ones and HI becomes the dividend exactly as it was supplied.
- R7: Once start is accepted, busy_o stays high for exactly W+1 cycles. HI and LO keep their earlier values until busy_o falls.
- R8: A start pulse given while busy_o is high is ignored. The running operation completes with its original operands and operation code.
- R9: The read port returns HI when rd_sel_i is 1 and LO when it is 0. stall_o is high exactly when a read is requested while busy_o is high.
- R10: With wr_en_i high, wr_data_i is loaded at the next clock edge into HI when wr_sel_i is 1, or into LO when it is 0. The other register is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches an operation when the unit is idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | W | Multiplicand or dividend |
| b_i | input | W | Multiplier or divisor |
| busy_o | output | 1 | Operation in flight |
| rd_req_i | input | 1 | Pipeline wants to read HI or LO |
| rd_sel_i | input | 1 | 1 selects HI, 0 selects LO |
| rd_data_o | output | W | Value of the selected register |
| stall_o | output | 1 | Read must wait, a result is pending |
| wr_en_i | input | 1 | Direct register load |
| wr_sel_i | input | 1 | 1 loads HI, 0 loads LO |
| wr_data_i | input | W | Value to load |

## Verification
The bench instantiates the unit with its default W of 32, and it computes the reference results in 64-bit arithmetic. At that width the edge operands become reachable as directed cases: the most negative value times itself, all-ones unsigned squares, the most negative value divided by -1, and division by zero in both signed and unsigned mode. The busy window of 33 cycles is counted directly on the port.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
    parameter int W = 32
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_main_o,
    output logic         neg_rem_o,
    output logic         div_zero_o
);
    logic is_signed, sa, sb;

    always_comb begin
        is_signed  = ~op_i[0];
        sa         = is_signed & a_i[W-1];
        sb         = is_signed & b_i[W-1];
        mag_a_o    = sa ? (~a_i + 1'b1) : a_i;
        mag_b_o    = sb ? (~b_i + 1'b1) : b_i;
        neg_main_o = sa ^ sb;
        neg_rem_o  = sa;
        div_zero_o = op_i[1] & (b_i == '0);
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int W = 32
) (
    input  logic           is_div_i,
    input  logic [2*W-1:0] p_i,
    input  logic [W-1:0]   m_i,
    output logic [2*W-1:0] p_o
);
    logic [W-1:0] hi, lo;
    logic [W:0]   sum, t, diff;

    always_comb begin
        hi   = p_i[2*W-1:W];
        lo   = p_i[W-1:0];
        sum  = {1'b0, hi} + (lo[0] ? {1'b0, m_i} : '0);
        t    = {hi, lo[W-1]};
        diff = t - {1'b0, m_i};
        if (!is_div_i) begin
            p_o = {sum, lo[W-1:1]};
        end else if (!diff[W]) begin
            p_o = {diff[W-1:0], lo[W-2:0], 1'b1};
        end else begin
            p_o = {t[W-1:0], lo[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
    parameter int W = 32
) (
    input  logic           is_div_i,
    input  logic           neg_main_i,
    input  logic           neg_rem_i,
    input  logic           div_zero_i,
    input  logic [W-1:0]   raw_a_i,
    input  logic [2*W-1:0] p_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   q, r;

    always_comb begin
        prod = neg_main_i ? (~p_i + 1'b1) : p_i;
        q    = neg_main_i ? (~p_i[W-1:0] + 1'b1) : p_i[W-1:0];
        r    = neg_rem_i ? (~p_i[2*W-1:W] + 1'b1) : p_i[2*W-1:W];
        if (!is_div_i) begin
            hi_o = prod[2*W-1:W];
            lo_o = prod[W-1:0];
        end else if (div_zero_i) begin
            hi_o = raw_a_i;
            lo_o = '1;
        end else begin
            hi_o = r;
            lo_o = q;
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    input  logic         rd_req_i,
    input  logic         rd_sel_i,
    output logic [W-1:0] rd_data_o,
    output logic         stall_o,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i
);
    import muldiv_pkg::*;

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           neg_main;
        logic           neg_rem;
        logic           dz;
        logic [W-1:0]   raw_a;
        logic [W-1:0]   m;
        logic [2*W-1:0] p;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
    } md_state_t;

    md_state_t      state_d, state_q;
    md_op_e         op_sel;
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_main, neg_rem, div_zero;
    logic [2*W-1:0] p_next;
    logic [W-1:0]   fix_hi, fix_lo;

    assign op_sel = md_op_e'(op_i);

    muldiv_prep #(.W(W)) u_prep (
        .op_i       (op_sel),
        .a_i        (a_i),
        .b_i        (b_i),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_main_o (neg_main),
        .neg_rem_o  (neg_rem),
        .div_zero_o (div_zero)
    );

    muldiv_step #(.W(W)) u_step (
        .is_div_i (state_q.is_div),
        .p_i      (state_q.p),
        .m_i      (state_q.m),
        .p_o      (p_next)
    );

    muldiv_fix #(.W(W)) u_fix (
        .is_div_i   (state_q.is_div),
        .neg_main_i (state_q.neg_main),
        .neg_rem_i  (state_q.neg_rem),
        .div_zero_i (state_q.dz),
        .raw_a_i    (state_q.raw_a),
        .p_i        (state_q.p),
        .hi_o       (fix_hi),
        .lo_o       (fix_lo)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            if (wr_sel_i) state_d.hi = wr_data_i;
            else          state_d.lo = wr_data_i;
        end
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.busy     = 1'b1;
                state_d.cnt      = CW'(W);
                state_d.is_div   = op_sel[1];
                state_d.neg_main = neg_main;
                state_d.neg_rem  = neg_rem;
                state_d.dz       = div_zero;
                state_d.raw_a    = a_i;
                state_d.m        = mag_b;
                state_d.p        = {{W{1'b0}}, mag_a};
            end
        end else if (state_q.cnt != '0) begin
            state_d.p   = p_next;
            state_d.cnt = state_q.cnt - 1'b1;
        end else begin
            state_d.hi   = fix_hi;
            state_d.lo   = fix_lo;
            state_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy_o    = state_q.busy;
    assign rd_data_o = rd_sel_i ? state_q.hi : state_q.lo;
    assign stall_o   = rd_req_i & state_q.busy;

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R7

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q.cnt != '0) |=> (busy_o && state_q.cnt == $past(state_q.cnt) - 1'b1)); // R8

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q.cnt != '0 && !wr_en_i) |=> ($stable(state_q.hi) && $stable(state_q.lo))); // R7

    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q.cnt == '0) |=> !busy_o); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= CW'(W)); // R7

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i && !busy_o) |=> (state_q.lo == $past(wr_data_i))); // R10

    AST_STALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && busy_o) |-> stall_o); // R9
endmodule

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic         busy_o;
    logic         rd_req_i = 1'b0, rd_sel_i = 1'b0;
    logic [W-1:0] rd_data_o;
    logic         stall_o;
    logic         wr_en_i = 1'b0, wr_sel_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    muldiv_hilo #(.W(W)) u_muldiv_hilo (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .rd_req_i(rd_req_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .stall_o(stall_o),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i)
    );

    function automatic logic [63:0] ref_result(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] ua, ub, uq, ur;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (op)
            2'b00: ref_result = 64'(sa * sb);
            2'b01: ref_result = ua * ub;
            2'b10: begin
                if (b == 0) ref_result = {a, 32'hFFFF_FFFF};
                else begin
                    q = sa / sb;
                    r = sa % sb;
                    ref_result = {r[31:0], q[31:0]};
                end
            end
            default: begin
                if (b == 0) ref_result = {a, 32'hFFFF_FFFF};
                else begin
                    uq = ua / ub;
                    ur = ua % ub;
                    ref_result = {ur[31:0], uq[31:0]};
                end
            end
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [W-1:0] val);
        rd_sel_i = sel;
        #1;
        val = rd_data_o;
    endtask

    task automatic run_op(string req, logic [1:0] op, logic [31:0] a, logic [31:0] b, bit poke);
        logic [W-1:0] prev_hi, v_hi, v_lo;
        logic [63:0]  exp;
        int n;
        @(negedge clk);
        read_reg(1'b1, prev_hi);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (busy_o && n < 100) begin
            n++;
            if (n == 2) begin
                rd_req_i = 1'b1; #1;
                chk("R9 stall while busy", 64'(stall_o), 64'd1);
                rd_req_i = 1'b0;
            end
            if (n == 3 && poke) begin
                start_i = 1'b1; op_i = ~op; a_i = ~a; b_i = b + 32'd3;
            end
            if (n == 4) start_i = 1'b0;
            if (n == 10) begin
                read_reg(1'b1, v_hi);
                chk("R7 HI held while busy", 64'(v_hi), 64'(prev_hi));
            end
            @(negedge clk);
        end
        chk("R7 busy length", 64'(n), 64'(W + 1));
        rd_req_i = 1'b1; #1;
        chk("R9 no stall when idle", 64'(stall_o), 64'd0);
        rd_req_i = 1'b0;
        read_reg(1'b1, v_hi);
        read_reg(1'b0, v_lo);
        exp = ref_result(op, a, b);
        chk(req, {v_hi, v_lo}, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin : main
        logic [W-1:0] v, v2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(1'b1, v);
        chk("R1 HI reset", 64'(v), 64'd0);
        read_reg(1'b0, v);
        chk("R1 LO reset", 64'(v), 64'd0);
        chk("R1 busy reset", 64'(busy_o), 64'd0);
        rd_req_i = 1'b1; #1;
        chk("R1 stall reset", 64'(stall_o), 64'd0);
        rd_req_i = 1'b0;

        run_op("R2 signed mul -1*-1", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R2 signed mul min*min", 2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R2 signed mul -5*7", 2'b00, 32'hFFFF_FFFB, 32'd7, 1'b0);
        run_op("R3 unsigned mul ones*ones", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R3 unsigned mul min*min", 2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R4 signed div -7/2", 2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R4 signed div 7/-2", 2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op("R4 signed div min/-1", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R5 unsigned div", 2'b11, 32'hFFFF_FFF0, 32'd7, 1'b0);
        run_op("R5 unsigned div small/large", 2'b11, 32'd5, 32'hFFFF_0000, 1'b0);
        run_op("R6 signed div by zero", 2'b10, 32'hFFFF_FF85, 32'd0, 1'b0);
        run_op("R6 unsigned div by zero", 2'b11, 32'h1234_5678, 32'd0, 1'b0);
        run_op("R8 start while busy ignored mul", 2'b00, 32'h0001_2345, 32'hFFFE_0001, 1'b1);
        run_op("R8 start while busy ignored div", 2'b11, 32'h9ABC_DEF0, 32'd13, 1'b1);

        for (int i = 0; i < 40; i++) begin
            logic [1:0]  rop;
            logic [31:0] ra, rb;
            rop = 2'($urandom());
            ra  = $urandom();
            rb  = $urandom();
            if (i % 5 == 0) rb = rb >> 20;
            if (i % 9 == 0) rb = 32'd0;
            case (rop)
                2'b00: run_op("R2 random signed mul", rop, ra, rb, 1'b0);
                2'b01: run_op("R3 random unsigned mul", rop, ra, rb, 1'b0);
                2'b10: run_op(rb == 0 ? "R6 random div zero" : "R4 random signed div", rop, ra, rb, 1'b0);
                default: run_op(rb == 0 ? "R6 random div zero" : "R5 random unsigned div", rop, ra, rb, 1'b0);
            endcase
        end

        @(negedge clk);
        read_reg(1'b0, v2);
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 32'hCAFE_0123;
        @(negedge clk);
        wr_en_i = 1'b0;
        read_reg(1'b1, v);
        chk("R10 load HI", 64'(v), 64'hCAFE_0123);
        read_reg(1'b0, v);
        chk("R10 LO untouched by HI load", 64'(v), 64'(v2));
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h0BAD_F00D;
        @(negedge clk);
        wr_en_i = 1'b0;
        read_reg(1'b0, v);
        chk("R10 load LO", 64'(v), 64'h0BAD_F00D);
        read_reg(1'b1, v);
        chk("R10 HI untouched by LO load", 64'(v), 64'hCAFE_0123);

        done = 1'b1;
        summary();
    end
endmodule